// File: doc/BRIEF.md
# Phase-Sequenced SPI Command Engine

This block is a register-programmed SPI master that performs one serial-memory transaction for each start command. Software first sets an opcode byte, a 32-bit address and a control word over a simple register bus. Writing the start bit then makes the engine assert one of four active-low chip selects and shift out a series of bytes in SPI mode 0. The series always begins with the opcode byte. An address phase of one to four bytes may follow, and then a data phase that either sends bytes from a 64-byte buffer or stores received bytes into it.

The register bus never stalls and carries no handshake: an access is taken on every cycle in which `reg_en` is high. Writes are committed at the rising clock edge. Reads are combinational from `reg_addr` and are valid in the same cycle. Address bit 7 separates the two windows. With bit 7 clear it selects a register: control 0x00, status 0x04, opcode 0x08, address 0x0C, mode 0x10. With bit 7 set it selects a data-buffer byte, indexed by bits 5:0 and carried in data bits 7:0. Status bits 1 and 2 are sticky and cleared by writing ones. The interrupt pin reflects them when bit 4 of the mode register is set.

Top module: `spi_cmd_engine`

## Requirements
- R1: Writing control with bit 14 set while idle, with a legal configuration, sets status bit 0 (busy) from the next cycle. When the last byte ends, busy clears and status bit 1 (done) is set.
- R2: While busy, exactly one chip select is low, namely `spi_cs_n[d]`, where d is control bits 1:0. All chip selects are high when idle.
- R3: The first byte sent is the opcode register value. When the address phase is on, it is followed by the low (a+1) bytes of the address register, most significant first, where a is control bits 3:2 (codes 0, 1, 2, 3 give 8, 16, 24, 32 bits).
- R4: SPI mode 0. `spi_sclk` idles low. Each byte goes MSB first. MOSI is stable across each rising edge, and MISO is sampled on that edge.
- R5: Control bit 11 enables the address phase and bit 12 enables the data phase. The data phase moves n bytes, where n is control bits 10:4. With both phases off, exactly one byte (the opcode) is sent.
- R6: Control bit 13 gives the direction. With 0 (read), received data bytes are stored in the buffer starting at offset 0. With 1 (write), buffer bytes are sent starting at offset 0.
- R7: A start with the data phase enabled and n equal to 0 or above 64 sets status bit 2 (fail). It leaves busy clear and asserts no chip select.
- R8: Writing control bit 15 while busy releases all chip selects and returns `spi_sclk` low by the next cycle. It also clears busy and sets fail.
- R9: A control write while busy, other than a kill, has no effect. The running transaction's bytes and chip select are unchanged, and control reads back its earlier value.
- R10: Writing status with bit 1 or bit 2 set clears that flag. Writing zeros leaves both flags as they were.
- R11: `irq` is high exactly when mode bit 4 is set and status bit 1 or bit 2 is set. Mode reads back bit 4.
- R12: Every byte of the data window can be written and read back over the register bus.
- R13: After reset, the status, control and mode registers read 0, every chip select is high, and `sclk` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register bus access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address; bit 7 selects the data window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest situations to reach are the ones that overlap a live transfer: a kill that lands in the middle of a byte, and a second start written while the first transaction is still shifting. The bench reaches both by writing the control register a fixed number of cycles after a start that is long enough to still be running. It then checks the pins and the status word at the next falling clock edge. A device model in the bench drives a position-dependent MISO byte stream and records every MOSI byte. This lets a sweep over all four chip selects, all four address widths and both directions check each byte's position against arithmetic expectations.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DEV_W = 2;
  localparam int NCS   = 1 << DEV_W;
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DAT} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_SHIFT} sq_state_t;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [1:0]       asz;
    logic [CNT_W-1:0] cnt;
    logic             aen;
    logic             den;
    logic             wr;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HC_W-1:0] hcnt;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic            active;
  logic            tick;

  assign tick = (hcnt == HC_W'(HALF - 1));
  assign mosi = sh[7];
  assign busy = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      sh     <= '0;
      bitn   <= '0;
      active <= 1'b0;
      sclk   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sclk   <= 1'b0;
        hcnt   <= '0;
      end else if (start && !active) begin
        active <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        hcnt   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (tick) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + HC_W'(1);
        end
      end
    end
  end

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);
  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (bus_we) mem[bus_addr] <= bus_wdata;
    if (eng_we) mem[eng_addr] <= eng_wdata;
  end

  assign bus_rdata = mem[bus_addr];
  assign eng_rdata = mem[eng_addr];
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           abort,
  input  xfer_cfg_t      cfg_in,
  input  logic [7:0]     opc_in,
  input  logic [31:0]    adr_in,
  output logic           sh_start,
  output logic [7:0]     sh_byte,
  input  logic           sh_busy,
  input  logic           sh_done,
  input  logic [7:0]     sh_rx,
  output logic           buf_we,
  output logic [AW-1:0]  buf_addr,
  output logic [7:0]     buf_wdata,
  input  logic [7:0]     buf_rdata,
  output logic           busy,
  output logic           finish,
  output logic [NCS-1:0] cs_n
);
  sq_state_t        state;
  xfer_cfg_t        cfg;
  logic [7:0]       opc;
  logic [31:0]      adr;
  phase_t           phase;
  phase_t           nxt_phase;
  logic [CNT_W-1:0] idx;
  logic             last;
  logic [4:0]       sa;
  logic [31:0]      ash;

  assign busy     = (state != SQ_IDLE);
  assign sh_start = (state == SQ_ISSUE);
  assign cs_n     = busy ? ~(NCS'(1) << cfg.dev) : '1;
  assign buf_addr = idx[AW-1:0];
  assign buf_wdata = sh_rx;
  assign buf_we   = (state == SQ_SHIFT) && sh_done && (phase == PH_DAT) && !cfg.wr;

  assign sa  = {cfg.asz - idx[1:0], 3'b000};
  assign ash = adr >> sa;

  always_comb begin
    case (phase)
      PH_OPC:  sh_byte = opc;
      PH_ADR:  sh_byte = ash[7:0];
      default: sh_byte = buf_rdata;
    endcase
  end

  always_comb begin
    nxt_phase = phase;
    last      = 1'b0;
    case (phase)
      PH_OPC: begin
        if (cfg.aen)      nxt_phase = PH_ADR;
        else if (cfg.den) nxt_phase = PH_DAT;
        else              last = 1'b1;
      end
      PH_ADR: begin
        if (idx[1:0] == cfg.asz) begin
          if (cfg.den) nxt_phase = PH_DAT;
          else         last = 1'b1;
        end
      end
      PH_DAT:  last = (idx == cfg.cnt - CNT_W'(1));
      default: last = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cfg    <= '0;
      opc    <= '0;
      adr    <= '0;
      phase  <= PH_OPC;
      idx    <= '0;
      finish <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (abort) begin
        state <= SQ_IDLE;
      end else begin
        case (state)
          SQ_IDLE: if (go) begin
            cfg   <= cfg_in;
            opc   <= opc_in;
            adr   <= adr_in;
            phase <= PH_OPC;
            idx   <= '0;
            state <= SQ_ISSUE;
          end
          SQ_ISSUE: state <= SQ_SHIFT;
          SQ_SHIFT: if (sh_done) begin
            if (last) begin
              state  <= SQ_IDLE;
              finish <= 1'b1;
            end else begin
              state <= SQ_ISSUE;
              phase <= nxt_phase;
              idx   <= (nxt_phase != phase) ? '0 : idx + CNT_W'(1);
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_kill_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cs_n == '1));
  p_issue_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int SCK_HALF  = 2,
  parameter int BUF_DEPTH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n,
  output logic           irq
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam logic [6:0] A_CTRL = 7'h00;
  localparam logic [6:0] A_STAT = 7'h04;
  localparam logic [6:0] A_OPC  = 7'h08;
  localparam logic [6:0] A_ADR  = 7'h0C;
  localparam logic [6:0] A_MODE = 7'h10;

  logic [13:0] ctrl_q;
  logic [7:0]  opc_q;
  logic [31:0] adr_q;
  logic        mode_ie, st_done, st_fail;

  logic        wr, is_buf, ctrl_wr, stat_wr;
  logic        busy, cfg_bad, start_req, go, cfg_err, kill, seq_finish;
  xfer_cfg_t   cfg_new;

  logic        sh_start, sh_busy, sh_done;
  logic [7:0]  sh_byte, sh_rx;
  logic        buf_we;
  logic [AW-1:0] buf_addr;
  logic [7:0]  buf_wdata, buf_rdata, bus_rdata;

  assign wr      = reg_en && reg_we;
  assign is_buf  = reg_addr[7];
  assign ctrl_wr = wr && !is_buf && (reg_addr[6:0] == A_CTRL);
  assign stat_wr = wr && !is_buf && (reg_addr[6:0] == A_STAT);

  assign cfg_new.dev = reg_wdata[DEV_W-1:0];
  assign cfg_new.asz = reg_wdata[3:2];
  assign cfg_new.cnt = reg_wdata[10:4];
  assign cfg_new.aen = reg_wdata[11];
  assign cfg_new.den = reg_wdata[12];
  assign cfg_new.wr  = reg_wdata[13];

  assign cfg_bad   = cfg_new.den && ((cfg_new.cnt == '0) || (cfg_new.cnt > CNT_W'(BUF_DEPTH)));
  assign start_req = ctrl_wr && reg_wdata[14] && !busy;
  assign go        = start_req && !cfg_bad;
  assign cfg_err   = start_req && cfg_bad;
  assign kill      = ctrl_wr && reg_wdata[15] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      opc_q   <= '0;
      adr_q   <= '0;
      mode_ie <= 1'b0;
      st_done <= 1'b0;
      st_fail <= 1'b0;
    end else begin
      if (ctrl_wr && !busy) ctrl_q <= reg_wdata[13:0];
      if (wr && !is_buf && reg_addr[6:0] == A_OPC)  opc_q <= reg_wdata[7:0];
      if (wr && !is_buf && reg_addr[6:0] == A_ADR)  adr_q <= reg_wdata;
      if (wr && !is_buf && reg_addr[6:0] == A_MODE) mode_ie <= reg_wdata[4];
      st_done <= (st_done && !(stat_wr && reg_wdata[1])) || seq_finish;
      st_fail <= (st_fail && !(stat_wr && reg_wdata[2])) || cfg_err || kill;
    end
  end

  assign irq = mode_ie && (st_done || st_fail);

  always_comb begin
    reg_rdata = '0;
    if (is_buf) begin
      reg_rdata = {24'b0, bus_rdata};
    end else begin
      case (reg_addr[6:0])
        A_CTRL:  reg_rdata = {18'b0, ctrl_q};
        A_STAT:  reg_rdata = {29'b0, st_fail, st_done, busy};
        A_OPC:   reg_rdata = {24'b0, opc_q};
        A_ADR:   reg_rdata = adr_q;
        A_MODE:  reg_rdata = {27'b0, mode_ie, 4'b0};
        default: reg_rdata = '0;
      endcase
    end
  end

  spi_eng_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .bus_we    (wr && is_buf),
    .bus_addr  (reg_addr[AW-1:0]),
    .bus_wdata (reg_wdata[7:0]),
    .bus_rdata (bus_rdata),
    .eng_we    (buf_we),
    .eng_addr  (buf_addr),
    .eng_wdata (buf_wdata),
    .eng_rdata (buf_rdata)
  );

  spi_eng_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .abort     (kill),
    .cfg_in    (cfg_new),
    .opc_in    (opc_q),
    .adr_in    (adr_q),
    .sh_start  (sh_start),
    .sh_byte   (sh_byte),
    .sh_busy   (sh_busy),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .buf_rdata (buf_rdata),
    .busy      (busy),
    .finish    (seq_finish),
    .cs_n      (spi_cs_n)
  );

  spi_eng_shift #(.HALF(SCK_HALF)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .abort (kill),
    .tx    (sh_byte),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .busy  (sh_busy),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  p_go_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  p_err_nocs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (spi_cs_n == '1));
  p_kill_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (st_fail && !busy));
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  // device model
  logic [7:0] cap [0:127];
  int   ncap = 0, nbit_in = 0, rbit = 0, cs_bad = 0, cs_falls = 0;
  logic [7:0] shin = '0;
  logic [3:0] exp_cs = 4'hF;
  wire  cs_idle = &spi_cs_n;

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 37) ^ 8'h5A;
  endfunction
  function automatic logic miso_bit(input int r);
    logic [7:0] b;
    b = resp(r / 8);
    return b[7 - (r % 8)];
  endfunction
  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 3) + s;
  endfunction

  always_comb spi_miso = miso_bit(rbit);

  always @(negedge cs_idle) begin
    ncap = 0; nbit_in = 0; rbit = 0; cs_falls++;
  end
  always @(posedge spi_sclk) begin
    shin = {shin[6:0], spi_mosi};
    nbit_in++;
    if (nbit_in % 8 == 0 && ncap < 128) begin
      cap[ncap] = shin;
      ncap++;
    end
    if (spi_cs_n !== exp_cs) cs_bad++;
  end
  always @(negedge spi_sclk) rbit++;

  task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int t = 0; t < 20000; t++) begin
      rd(8'h04, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] ctl_word(input int dev, input int asz, input int cnt,
      input bit aen, input bit den, input bit wrd);
    return 32'(dev) | (32'(asz) << 2) | (32'(cnt) << 4) | (32'(aen) << 11)
         | (32'(den) << 12) | (32'(wrd) << 13);
  endfunction

  task automatic xfer(input int dev, input int asz, input int cnt, input bit aen,
      input bit den, input bit wrd, input logic [7:0] opc, input logic [31:0] adr);
    int na, nd, bad;
    logic [31:0] st, v;
    na = aen ? asz + 1 : 0;
    nd = den ? cnt : 0;
    if (den && wrd)
      for (int i = 0; i < cnt; i++) wr(8'(8'h80 + i), 32'(pat(i, opc)));
    wr(8'h08, 32'(opc));
    wr(8'h0C, adr);
    wr(8'h04, 32'h6);
    exp_cs = ~(4'b1 << dev);
    cs_bad = 0;
    wr(8'h00, ctl_word(dev, asz, cnt, aen, den, wrd) | 32'h4000);
    wait_idle();
    rd(8'h04, st);
    chk_eq("R1", "status after transaction", st, 32'h2);
    chk_eq("R5", "bytes on the bus", 32'(ncap), 32'(1 + na + nd));
    chk_eq("R3", "opcode byte", 32'(cap[0]), 32'(opc));
    chk_eq("R2", "wrong chip select samples", 32'(cs_bad), 0);
    chk_eq("R4", "sclk idle level", 32'(spi_sclk), 0);
    if (aen) begin
      bad = 0;
      for (int k = 0; k < na; k++)
        if (cap[1 + k] !== 8'(adr >> (8 * (asz - k)))) bad++;
      chk_eq("R3", "address byte mismatches", 32'(bad), 0);
    end
    if (den) begin
      bad = 0;
      for (int i = 0; i < cnt; i++) begin
        if (wrd) begin
          if (cap[1 + na + i] !== pat(i, opc)) bad++;
        end else begin
          rd(8'(8'h80 + i), v);
          if (v[7:0] !== resp(1 + na + i)) bad++;
        end
      end
      chk_eq("R6", wrd ? "write data mismatches" : "read data mismatches", 32'(bad), 0);
    end
  endtask

  initial begin
    #(150000 * 5);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    int falls0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(8'h04, v); chk_eq("R13", "status after reset", v, 0);
    rd(8'h00, v); chk_eq("R13", "control after reset", v, 0);
    rd(8'h10, v); chk_eq("R13", "mode after reset", v, 0);
    chk_eq("R13", "chip selects after reset", 32'(spi_cs_n), 32'hF);
    chk_eq("R13", "sclk/irq after reset", {30'b0, spi_sclk, irq}, 0);

    // R12 data window
    for (int i = 0; i < 64; i++) wr(8'(8'h80 + i), 32'(8'hC3 ^ 8'(i * 5)));
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        rd(8'(8'h80 + i), v);
        if (v !== 32'(8'hC3 ^ 8'(i * 5))) bad++;
      end
      chk_eq("R12", "buffer readback mismatches", 32'(bad), 0);
    end

    // sweep: every device, every address width, both directions
    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 4; a++)
        xfer(d, a, 1 + d + 2 * a, 1'b1, 1'b1, (a % 2) == 1,
             8'(8'h10 + d * 4 + a), 32'hA1B2C3D4 ^ 32'(d * 97 + a));

    // R5 phase enables
    xfer(1, 0, 5, 1'b0, 1'b0, 1'b0, 8'h06, 32'h0);
    xfer(2, 3, 3, 1'b1, 1'b0, 1'b0, 8'h9F, 32'h01020304);
    xfer(3, 0, 6, 1'b0, 1'b1, 1'b1, 8'h02, 32'h0);
    // R6 full-size transfers
    xfer(0, 2, 64, 1'b1, 1'b1, 1'b1, 8'h12, 32'h00ABCDEF);
    xfer(1, 1, 64, 1'b1, 1'b1, 1'b0, 8'h13, 32'h00005A5A);

    // R7 bad data counts
    wr(8'h04, 32'h6);
    falls0 = cs_falls;
    wr(8'h00, ctl_word(0, 0, 0, 1'b1, 1'b1, 1'b0) | 32'h4000);
    rd(8'h04, v); chk_eq("R7", "status for count 0", v, 32'h4);
    wr(8'h04, 32'h6);
    wr(8'h00, ctl_word(2, 0, 65, 1'b0, 1'b1, 1'b1) | 32'h4000);
    rd(8'h04, v); chk_eq("R7", "status for count 65", v, 32'h4);
    repeat (40) @(negedge clk);
    chk_eq("R7", "chip select falls on error", 32'(cs_falls - falls0), 0);

    // R10 write-one-to-clear; fail is set, now add done
    exp_cs = 4'hE; cs_bad = 0;
    wr(8'h00, ctl_word(0, 0, 0, 1'b0, 1'b0, 1'b0) | 32'h4000);
    wait_idle();
    rd(8'h04, v); chk_eq("R10", "both flags set", v, 32'h6);
    // R11 interrupt masked
    chk_eq("R11", "irq with mode clear", 32'(irq), 0);
    wr(8'h10, 32'h10);
    rd(8'h10, v); chk_eq("R11", "mode readback", v, 32'h10);
    chk_eq("R11", "irq enabled with flags", 32'(irq), 1);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk_eq("R10", "writing zero keeps flags", v, 32'h6);
    wr(8'h04, 32'h2);
    rd(8'h04, v); chk_eq("R10", "clear done only", v, 32'h4);
    chk_eq("R11", "irq with fail only", 32'(irq), 1);
    wr(8'h04, 32'h4);
    rd(8'h04, v); chk_eq("R10", "clear fail", v, 32'h0);
    chk_eq("R11", "irq with no flags", 32'(irq), 0);
    wr(8'h10, 32'h0);

    // R9 start while busy
    wr(8'h08, 32'h03); wr(8'h0C, 32'h4455);
    exp_cs = 4'hB; cs_bad = 0;
    c0 = ctl_word(2, 1, 4, 1'b1, 1'b1, 1'b0);
    wr(8'h00, c0 | 32'h4000);
    repeat (20) @(negedge clk);
    wr(8'h00, ctl_word(0, 0, 0, 1'b0, 1'b0, 1'b1) | 32'h4000);
    rd(8'h00, v); chk_eq("R9", "control unchanged while busy", v, c0);
    wait_idle();
    chk_eq("R9", "bytes of first transaction", 32'(ncap), 7);
    chk_eq("R9", "chip select unchanged", 32'(cs_bad), 0);
    rd(8'h04, v); chk_eq("R9", "status after ignored start", v, 32'h2);

    // R8 kill mid-byte
    wr(8'h04, 32'h6);
    exp_cs = 4'h7;
    wr(8'h00, ctl_word(3, 3, 16, 1'b1, 1'b1, 1'b0) | 32'h4000);
    repeat (53) @(negedge clk);
    wr(8'h00, 32'h8000);
    chk_eq("R8", "chip selects after kill", 32'(spi_cs_n), 32'hF);
    chk_eq("R8", "sclk after kill", 32'(spi_sclk), 0);
    rd(8'h04, v); chk_eq("R8", "status after kill", v, 32'h4);
    // engine usable after kill
    xfer(0, 0, 2, 1'b1, 1'b1, 1'b0, 8'h0B, 32'h77);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule